// File: doc/BRIEF.md
# Indirect register access bridge

The bridge sits on a 64-bit memory-mapped host port and gives the host a path into a small 32-bit register space that is not mapped directly. The host loads a word address together with a command bit into one window register. The bridge turns that command into a single transaction on a downstream request/acknowledge register bus. The command bit stays set while the access is in flight and clears itself once the access completes, so software posts a command and then polls for completion. Read results land in a capture register. Write values are staged beforehand in a separate register. A constant parameter word, fixed at build time, describes the serial controller that sits behind the bridge.

Host reads are combinational: `host_rdata` always shows the register selected by `host_addr`. Host writes take effect on the clock edge that samples `host_wr` high. The reset input asserts at once. Its release passes through a two-stage synchronizer, so the bridge leaves reset on the second rising edge after `rst_n` goes high, and the third edge is the first functional one.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the command register, read capture register and write staging register all read as zero, and `dn_req` is low.
- R2: Offset 0x08 reads a constant word. Bit 1 is the LSB-first flag. Bits 7:2 are the data width, bits 13:8 the chip-select count, bit 14 the clock polarity, bit 15 the clock phase, bits 31:22 the serial clock field and bits 47:32 the peripheral identifier. All other bits are zero.
- R3: A host write to offset 0x10 while no access is pending stores `host_wdata[WADDR_W-1:0]` as the word address, with upper address bits dropped. A read of 0x10 returns that address in its low bits, the write-busy flag in bit 8, the read-busy flag in bit 9, and zeros elsewhere. A command write with neither bit 8 nor bit 9 set starts no access.
- R4: A command write that is accepted with bit 8 set makes bit 8 read as 1 from the next cycle. In that same next cycle it raises `dn_req` for exactly one cycle, with `dn_we`=1, `dn_addr` equal to the stored address and `dn_wdata` equal to the staged write value.
- R5: An accepted command with bit 9 set, and bit 8 clear, issues one `dn_req` with `dn_we`=0. On the edge that samples `dn_ack`, `dn_rdata` is captured into bits 31:0 of offset 0x18 and bit 9 clears.
- R6: When bits 8 and 9 are both 1 in one command, only a write is performed. Bit 9 never becomes set, and the two busy flags are never set together.
- R7: A command write that arrives while an access is pending, including in the cycle its acknowledge arrives, is ignored. The stored address and the busy flags keep their values.
- R8: The acknowledge may come in the request cycle itself or any number of cycles later. While an access is pending and unacknowledged, no new request is issued, and the edge that samples the acknowledge clears the busy flag.
- R9: Offset 0x20 holds `host_wdata[31:0]` and reads back zero-extended. Bits 63:32 of 0x18 read as zero. Any other offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | HOST_AW | Host byte offset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data for `host_addr`, combinational |
| dn_req | output | 1 | Downstream request pulse |
| dn_we | output | 1 | Downstream write enable, valid with `dn_req` |
| dn_addr | output | WADDR_W | Downstream word address |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_rdata | input | 32 | Downstream read data, valid with `dn_ack` |

## Verification
The bench builds the bridge with a 3-bit word address. This is exactly enough for word indexes 0 to 6 and index 7, and it brings address truncation of an oversized written address within reach. It sets every parameter-word field to a distinct non-zero value, except clock phase, which it leaves at zero. This lets a swapped or shifted field show up in a single read. A behavioural slave with a programmable delay covers acknowledges in the request cycle, after a short wait and after a long wait. The long wait leaves room for a second command to arrive while the first is still pending.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int HOST_DW = 64;
  localparam int DN_DW   = 32;

  localparam logic [7:0] OFS_PARAM = 8'h08;
  localparam logic [7:0] OFS_CMD   = 8'h10;
  localparam logic [7:0] OFS_RDATA = 8'h18;
  localparam logic [7:0] OFS_WDATA = 8'h20;

  localparam int CMD_WR_BIT = 8;
  localparam int CMD_RD_BIT = 9;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic wr;
    logic rd;
  } cmd_flags_t;
endpackage

// File: rtl/ibr_rst_sync.sv
module ibr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_out = stage2_q;
endmodule

// File: rtl/ibr_param_word.sv
module ibr_param_word #(
  parameter int          LSB_FIRST = 0,
  parameter int          DATA_W    = 32,
  parameter int          NUM_CS    = 1,
  parameter int          CPOL      = 0,
  parameter int          CPHA      = 0,
  parameter logic [9:0]  SCLK_FLD  = 10'd0,
  parameter logic [15:0] PERIPH_ID = 16'd0
) (
  output logic [63:0] word
);
  localparam logic [5:0] DW_F  = 6'(DATA_W);
  localparam logic [5:0] CS_F  = 6'(NUM_CS);
  localparam logic       LSB_F = (LSB_FIRST != 0);
  localparam logic       POL_F = (CPOL != 0);
  localparam logic       PHA_F = (CPHA != 0);

  // field order is fixed by the software that decodes this word
  assign word = {16'd0, PERIPH_ID, SCLK_FLD, 6'd0, PHA_F, POL_F,
                 CS_F, DW_F, LSB_F, 1'b0};
endmodule

// File: rtl/ibr_host_regs.sv
module ibr_host_regs
  import ibr_pkg::*;
#(
  parameter int HOST_AW = 6,
  parameter int WADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HOST_AW-1:0]   host_addr,
  input  logic                 host_wr,
  input  logic [HOST_DW-1:0]   host_wdata,
  output logic [HOST_DW-1:0]   host_rdata,
  input  logic                 busy_wr,
  input  logic                 busy_rd,
  input  logic [DN_DW-1:0]     rd_data,
  input  logic [63:0]          param_word,
  output logic [WADDR_W-1:0]   cmd_addr,
  output logic [DN_DW-1:0]     wr_data,
  output cmd_flags_t           start
);
  localparam logic [HOST_AW-1:0] A_PARAM = HOST_AW'(OFS_PARAM);
  localparam logic [HOST_AW-1:0] A_CMD   = HOST_AW'(OFS_CMD);
  localparam logic [HOST_AW-1:0] A_RDATA = HOST_AW'(OFS_RDATA);
  localparam logic [HOST_AW-1:0] A_WDATA = HOST_AW'(OFS_WDATA);

  logic                hit_cmd;
  logic                hit_wdata;
  logic                accept;
  logic                addr_en;
  logic                wdat_en;
  logic [WADDR_W-1:0]  addr_d, addr_q;
  logic [DN_DW-1:0]    wdat_d, wdat_q;
  logic                unused_wdata_hi;

  assign unused_wdata_hi = |host_wdata[HOST_DW-1:DN_DW];

  always_comb begin
    hit_cmd   = host_wr && (host_addr == A_CMD);
    hit_wdata = host_wr && (host_addr == A_WDATA);
    accept    = hit_cmd && !busy_wr && !busy_rd;
    start.wr  = accept && host_wdata[CMD_WR_BIT];
    start.rd  = accept && host_wdata[CMD_RD_BIT] && !host_wdata[CMD_WR_BIT];
    addr_en   = accept;
    addr_d    = host_wdata[WADDR_W-1:0];
    wdat_en   = hit_wdata;
    wdat_d    = host_wdata[DN_DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdat_q <= '0;
    end else if (wdat_en) begin
      wdat_q <= wdat_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      A_PARAM: host_rdata = param_word;
      A_CMD: begin
        host_rdata[WADDR_W-1:0] = addr_q;
        host_rdata[CMD_WR_BIT]  = busy_wr;
        host_rdata[CMD_RD_BIT]  = busy_rd;
      end
      A_RDATA: host_rdata[DN_DW-1:0] = rd_data;
      A_WDATA: host_rdata[DN_DW-1:0] = wdat_q;
      default: host_rdata = '0;
    endcase
  end

  assign cmd_addr = addr_q;
  assign wr_data  = wdat_q;
endmodule

// File: rtl/ibr_cmd_seq.sv
module ibr_cmd_seq
  import ibr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_flags_t        start,
  input  logic              dn_ack,
  input  logic [DN_DW-1:0]  dn_rdata,
  output logic              busy_wr,
  output logic              busy_rd,
  output logic [DN_DW-1:0]  rd_data,
  output logic              dn_req,
  output logic              dn_we
);
  seq_state_e        state_d, state_q;
  logic              bw_d, bw_q;
  logic              br_d, br_q;
  logic              cap_en;
  logic [DN_DW-1:0]  rd_q;

  always_comb begin
    state_d = state_q;
    bw_d    = bw_q;
    br_d    = br_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start.wr) begin
          bw_d    = 1'b1;
          state_d = SEQ_REQ;
        end else if (start.rd) begin
          br_d    = 1'b1;
          state_d = SEQ_REQ;
        end
      end
      SEQ_REQ: begin
        if (dn_ack) begin
          bw_d    = 1'b0;
          br_d    = 1'b0;
          state_d = SEQ_IDLE;
        end else begin
          state_d = SEQ_WAIT;
        end
      end
      SEQ_WAIT: begin
        if (dn_ack) begin
          bw_d    = 1'b0;
          br_d    = 1'b0;
          state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
    cap_en = br_q && dn_ack && (state_q != SEQ_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      bw_q    <= 1'b0;
      br_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bw_q    <= bw_d;
      br_q    <= br_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (cap_en) begin
      rd_q <= dn_rdata;
    end
  end

  assign busy_wr = bw_q;
  assign busy_rd = br_q;
  assign rd_data = rd_q;
  assign dn_req  = (state_q == SEQ_REQ);
  assign dn_we   = bw_q;
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int          HOST_AW   = 6,
  parameter int          WADDR_W   = 8,
  parameter int          LSB_FIRST = 0,
  parameter int          DATA_W    = 32,
  parameter int          NUM_CS    = 1,
  parameter int          CPOL      = 0,
  parameter int          CPHA      = 0,
  parameter logic [9:0]  SCLK_FLD  = 10'd0,
  parameter logic [15:0] PERIPH_ID = 16'd0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HOST_AW-1:0]  host_addr,
  input  logic                host_wr,
  input  logic [63:0]         host_wdata,
  output logic [63:0]         host_rdata,
  output logic                dn_req,
  output logic                dn_we,
  output logic [WADDR_W-1:0]  dn_addr,
  output logic [31:0]         dn_wdata,
  input  logic                dn_ack,
  input  logic [31:0]         dn_rdata
);
  logic               rst_sync_n;
  logic               busy_wr;
  logic               busy_rd;
  logic [DN_DW-1:0]   rd_data;
  logic [63:0]        param_word;
  logic [WADDR_W-1:0] cmd_addr;
  logic [DN_DW-1:0]   wr_data;
  cmd_flags_t         start;

  ibr_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  ibr_param_word #(
    .LSB_FIRST (LSB_FIRST),
    .DATA_W    (DATA_W),
    .NUM_CS    (NUM_CS),
    .CPOL      (CPOL),
    .CPHA      (CPHA),
    .SCLK_FLD  (SCLK_FLD),
    .PERIPH_ID (PERIPH_ID)
  ) u_param (
    .word (param_word)
  );

  ibr_host_regs #(
    .HOST_AW (HOST_AW),
    .WADDR_W (WADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .busy_wr    (busy_wr),
    .busy_rd    (busy_rd),
    .rd_data    (rd_data),
    .param_word (param_word),
    .cmd_addr   (cmd_addr),
    .wr_data    (wr_data),
    .start      (start)
  );

  ibr_cmd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .dn_ack   (dn_ack),
    .dn_rdata (dn_rdata),
    .busy_wr  (busy_wr),
    .busy_rd  (busy_rd),
    .rd_data  (rd_data),
    .dn_req   (dn_req),
    .dn_we    (dn_we)
  );

  assign dn_addr  = cmd_addr;
  assign dn_wdata = wr_data;
endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk
  import ibr_pkg::*;
#(
  parameter int HOST_AW = 6,
  parameter int WADDR_W = 8
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [HOST_AW-1:0] host_addr,
  input logic               host_wr,
  input logic [63:0]        host_wdata,
  input logic               dn_req,
  input logic               dn_we,
  input logic               dn_ack,
  input logic [31:0]        dn_rdata,
  input logic               busy_wr,
  input logic               busy_rd,
  input logic [31:0]        rd_data,
  input logic [WADDR_W-1:0] cmd_addr
);
  localparam logic [HOST_AW-1:0] A_CMD = HOST_AW'(OFS_CMD);

  logic cmd_wr;
  logic busy;
  assign cmd_wr = host_wr && (host_addr == A_CMD);
  assign busy   = busy_wr || busy_rd;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dn_req |=> !dn_req); // R4
  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_wr && !busy && (host_wdata[CMD_WR_BIT] || host_wdata[CMD_RD_BIT])) |=> dn_req); // R4
  AST_WE_FOLLOWS_KIND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dn_req |-> (dn_we == busy_wr) && busy); // R5
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_rd && dn_ack) |=> (rd_data == $past(dn_rdata))); // R5
  AST_BOTH_BITS_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_wr && !busy && host_wdata[CMD_WR_BIT] && host_wdata[CMD_RD_BIT])
      |=> (dn_req && dn_we && !busy_rd)); // R6
  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(busy_wr && busy_rd)); // R6
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_wr && busy) |=> $stable(cmd_addr)); // R7
  AST_NO_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !dn_ack) |=> !dn_req); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && dn_ack) |=> !busy); // R8
endmodule

bind ibr_bridge ibr_bridge_chk #(
  .HOST_AW (HOST_AW),
  .WADDR_W (WADDR_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .dn_req     (dn_req),
  .dn_we      (dn_we),
  .dn_ack     (dn_ack),
  .dn_rdata   (dn_rdata),
  .busy_wr    (busy_wr),
  .busy_rd    (busy_rd),
  .rd_data    (rd_data),
  .cmd_addr   (cmd_addr)
);

// File: tb/test_ibr_bridge.sv
`timescale 1ns/1ps
module test_ibr_bridge;
  localparam int AW = 6;
  localparam int WW = 3;
  localparam logic [63:0] PARAM_EXP = (64'd1 << 1) | (64'd16 << 2) | (64'd3 << 8) |
                                      (64'd1 << 14) | (64'h2A5 << 22) | (64'hC3A1 << 32);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] host_addr;
  logic          host_wr;
  logic [63:0]   host_wdata;
  logic [63:0]   host_rdata;
  logic          dn_req, dn_we;
  logic [WW-1:0] dn_addr;
  logic [31:0]   dn_wdata;
  logic          dn_ack;
  logic [31:0]   dn_rdata;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ibr_bridge #(
    .HOST_AW(AW), .WADDR_W(WW), .LSB_FIRST(1), .DATA_W(16), .NUM_CS(3),
    .CPOL(1), .CPHA(0), .SCLK_FLD(10'h2A5), .PERIPH_ID(16'hC3A1)
  ) i_ibr_bridge (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .dn_req(dn_req),
    .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ack(dn_ack),
    .dn_rdata(dn_rdata)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // downstream slave with programmable acknowledge delay
  logic [31:0] mem [8];
  int s_delay = 0, s_cnt = 0, s_nwr = 0, s_nrd = 0;
  logic s_busy = 1'b0, s_we = 1'b0;
  logic [WW-1:0] s_addr = '0;
  logic [31:0] s_data = '0;

  always @(negedge clk) begin
    dn_ack   = 1'b0;
    dn_rdata = 32'hBADB_AD00;
    if (dn_req) begin
      s_addr = dn_addr; s_we = dn_we; s_data = dn_wdata; s_cnt = s_delay; s_busy = 1'b1;
    end
    if (s_busy) begin
      if (s_cnt == 0) begin
        dn_ack = 1'b1;
        if (s_we) begin mem[s_addr] = s_data; s_nwr++; end
        else begin dn_rdata = mem[s_addr]; s_nrd++; end
        s_busy = 1'b0;
      end else s_cnt--;
    end
  end

  // behavioural reference model, updated on each edge
  int rcnt = 0;
  int m_phase = 0;
  logic m_bw = 0, m_br = 0;
  logic [WW-1:0] m_addr = '0;
  logic [31:0] m_rd = '0, m_wd = '0;
  logic started = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n || rcnt < 2) begin
      if (!rst_n) rcnt = 0; else rcnt++;
      m_phase = 0; m_bw = 0; m_br = 0; m_addr = '0; m_rd = '0; m_wd = '0;
    end else begin
      automatic bit pend = m_bw || m_br;
      if (m_phase != 0 && dn_ack) begin
        if (m_br) m_rd = dn_rdata;
        m_bw = 0; m_br = 0; m_phase = 0;
      end else if (m_phase == 1) m_phase = 2;
      if (host_wr && host_addr == 6'h10 && !pend) begin
        m_addr = host_wdata[WW-1:0];
        if (host_wdata[8]) begin m_bw = 1; m_phase = 1; end
        else if (host_wdata[9]) begin m_br = 1; m_phase = 1; end
      end
      if (host_wr && host_addr == 6'h20) m_wd = host_wdata[31:0];
    end
  end

  function automatic logic [63:0] exp_rdata(input logic [AW-1:0] a);
    case (a)
      6'h08: return PARAM_EXP;
      6'h10: return {54'd0, m_br, m_bw, 5'd0, m_addr};
      6'h18: return {32'd0, m_rd};
      6'h20: return {32'd0, m_wd};
      default: return 64'd0;
    endcase
  endfunction

  always begin
    @(posedge clk); #1;
    if (started) begin
      chk(dn_req == (m_phase == 1), "R4/R8 dn_req vs model", 64'(dn_req), 64'(m_phase == 1));
      if (dn_req && m_phase == 1) begin
        chk(dn_we == m_bw, "R4/R5 dn_we", 64'(dn_we), 64'(m_bw));
        chk(dn_addr == m_addr, "R3 dn_addr", 64'(dn_addr), 64'(m_addr));
        if (m_bw) chk(dn_wdata == m_wd, "R4 dn_wdata", 64'(dn_wdata), 64'(m_wd));
      end
      chk(host_rdata == exp_rdata(host_addr), "R9 host_rdata vs model", host_rdata, exp_rdata(host_addr));
    end
  end

  task automatic hwrite(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk); host_addr = a; host_wr = 1'b1; host_wdata = d;
    @(negedge clk); host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic hread(input logic [AW-1:0] a, output logic [63:0] v);
    @(negedge clk); host_addr = a; #1 v = host_rdata;
  endtask

  task automatic wait_idle;
    logic [63:0] v;
    for (int i = 0; i < 1000; i++) begin
      hread(6'h10, v);
      if (v[9:8] == 2'b00) break;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    int nw, nr;
    for (int i = 0; i < 8; i++) mem[i] = 32'hC0DE_0000 + i;
    rst_n = 1'b0; host_addr = '0; host_wr = 1'b0; host_wdata = '0;
    dn_ack = 1'b0; dn_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    hread(6'h10, v); chk(v == 0, "R1 cmd after reset", v, 0);
    hread(6'h18, v); chk(v == 0, "R1 rdata after reset", v, 0);
    hread(6'h20, v); chk(v == 0, "R1 wdata after reset", v, 0);
    chk(dn_req == 0, "R1 no request after reset", 64'(dn_req), 0);
    // R2 parameter word
    hread(6'h08, v); chk(v == PARAM_EXP, "R2 parameter word", v, PARAM_EXP);
    // R9 staging register and unmapped offset
    hwrite(6'h20, 64'hFFFF_FFFF_1234_5678);
    hread(6'h20, v); chk(v == 64'h1234_5678, "R9 wdata zero-extended", v, 64'h1234_5678);
    hread(6'h30, v); chk(v == 0, "R9 unmapped offset", v, 0);
    // R4 write with delayed ack
    s_delay = 3;
    hwrite(6'h10, 64'h103);
    hread(6'h10, v); chk(v == 64'h103, "R4 write busy visible", v, 64'h103);
    wait_idle;
    chk(s_nwr == 1, "R4 one downstream write", 64'(s_nwr), 1);
    chk(mem[3] == 32'h1234_5678, "R4 write value delivered", 64'(mem[3]), 64'h1234_5678);
    // R5 reads
    s_delay = 5;
    hwrite(6'h10, 64'h203);
    hread(6'h10, v); chk(v == 64'h203, "R5 read busy visible", v, 64'h203);
    wait_idle;
    hread(6'h18, v); chk(v == 64'h1234_5678, "R5 read capture", v, 64'h1234_5678);
    hwrite(6'h10, 64'h202); wait_idle;
    hread(6'h18, v); chk(v == 64'hC0DE_0002, "R5 read prefilled word", v, 64'hC0DE_0002);
    // R8 ack in request cycle, word 6
    s_delay = 0;
    hwrite(6'h20, 64'hA5A5_0F0F);
    hwrite(6'h10, 64'h106); wait_idle;
    chk(mem[6] == 32'hA5A5_0F0F, "R8 zero-delay write", 64'(mem[6]), 64'hA5A5_0F0F);
    hwrite(6'h10, 64'h206); wait_idle;
    hread(6'h18, v); chk(v == 64'hA5A5_0F0F, "R8 zero-delay read", v, 64'hA5A5_0F0F);
    // R6 both bits set
    nw = s_nwr; nr = s_nrd;
    hwrite(6'h20, 64'h55AA_33CC);
    hwrite(6'h10, 64'h300); wait_idle;
    chk(s_nwr == nw + 1 && s_nrd == nr, "R6 only write performed", 64'(s_nrd), 64'(nr));
    chk(mem[0] == 32'h55AA_33CC, "R6 write value", 64'(mem[0]), 64'h55AA_33CC);
    // R7 command while busy ignored
    s_delay = 20; nw = s_nwr; nr = s_nrd;
    hwrite(6'h20, 64'h1111_2222);
    hwrite(6'h10, 64'h105);
    hwrite(6'h10, 64'h201);
    hread(6'h10, v); chk(v == 64'h105, "R7 busy command ignored", v, 64'h105);
    wait_idle;
    repeat (30) @(negedge clk);
    chk(s_nrd == nr && s_nwr == nw + 1, "R7 no extra access", 64'(s_nrd), 64'(nr));
    hread(6'h10, v); chk(v == 64'h005, "R7 address kept", v, 64'h005);
    // R3 address only, truncated
    nw = s_nwr; nr = s_nrd;
    hwrite(6'h10, 64'h0F);
    repeat (5) @(negedge clk);
    hread(6'h10, v); chk(v == 64'h007, "R3 truncated address", v, 64'h007);
    chk(s_nwr == nw && s_nrd == nr, "R3 no access without command bit", 64'(s_nwr), 64'(nw));

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule